// File: doc/BRIEF.md
# LED Driver Special-Mode Sequencer and Brightness Register

This block sits beside the serial data path of an eight-channel constant-current LED driver. At every rising serial clock edge it samples two control pins: the output-off pin, which blanks the outputs when high, and the latch strobe. It looks for two five-clock patterns of those pins. One pattern switches the driver from normal mode into special mode. The other switches it back and tells the data path to clear its data.

In special mode the latch strobe no longer reaches the output latch. Instead it copies the shift register into an 8-bit brightness register. That register wakes up all ones and keeps its contents across mode changes. Its range bit and 6-bit gain field are passed to the current reference. The block also blocks the output latch for the single strobe that belongs to an entry pattern in progress, so the data path never latches data while the driver is switching modes.

Top module: `ledctl_mode_seq`

## Requirements
- R1: Samples are taken as (outs_off, strobe) pairs. The entry pattern, oldest first, is (1,0), (0,0), (1,0), (1,1), (1,0). In normal mode, when the last five samples match it, special_mode reads 1 after the fifth edge. If a sample breaks a partial match, that sample may begin a new match.
- R2: The exit pattern is (1,0), (0,0), (1,0), (1,0), (1,0). In special mode, when the last five samples match it, special_mode reads 0 after the fifth edge. A sequence that differs in any one sample leaves the mode unchanged.
- R3: After a synchronous reset (rst_n low at an edge), the outputs read as follows: special_mode 0, hc_range 1, gain 63, and latch_inhibit and data_clear 0 while strobe is low.
- R4: In normal mode, strobe high outside an entry pattern leaves latch_inhibit at 0.
- R5: While special_mode is 1, latch_inhibit is 1. A sample with strobe high copies shreg into the brightness register at that edge.
- R6: Within the brightness code, bit 1 drives hc_range, where 0 selects the lower half range and 1 the upper. Bits 7 down to 2 drive gain, with bit 7 as its MSB. Bit 0 is reserved and reaches no output.
- R7: The brightness register changes only on a special-mode strobe sample. Its contents survive both mode changes.
- R8: data_clear is 1 only while the fifth sample of an exit pattern is present in special mode, that is, during the cycle before the edge that returns to normal mode.
- R9: After any mode change, a pattern matches only when all five of its samples were taken after that change.
- R10: In normal mode, latch_inhibit is 1 when strobe is high at a sample that extends a partial match of the entry pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| outs_off | input | 1 | Output-off pin level (1 blanks the outputs) |
| strobe | input | 1 | Latch strobe pin level |
| shreg | input | 8 | Parallel view of the serial shift register |
| special_mode | output | 1 | 1 while in special mode |
| latch_inhibit | output | 1 | Blocks the output latch from taking data |
| data_clear | output | 1 | Tells the data path to zero its data at this edge |
| hc_range | output | 1 | Current range select from the brightness code |
| gain | output | 6 | Gain step within the selected range |

## Verification
A window or match-counter fault shows at special_mode one edge after the fifth sample of a pattern, or one edge after a near miss that should have been ignored. Wrong prefix tracking shows combinationally on latch_inhibit during the strobe sample itself. A brightness register fault shows at hc_range and gain one edge after a special-mode strobe, or as a change where a hold was expected. A missed restart of the window after a mode change shows as a mode flip four samples too early.

// File: rtl/ledctl_mode_pkg.sv
// Package: shared defaults and the mode type for the special-mode sequencer.
// Assumes: patterns are stored oldest step in bit 0.
package ledctl_mode_pkg;

    // Length of every control-pin pattern, in serial clock edges.
    localparam int SEQ_LEN_DEF = 5;

    // Entry pattern: output-off levels and strobe levels, step 0 in bit 0.
    localparam logic [SEQ_LEN_DEF-1:0] ENTRY_OFF_DEF = 5'b11101;
    localparam logic [SEQ_LEN_DEF-1:0] ENTRY_LAT_DEF = 5'b01000;

    // Exit pattern: strobe stays low on every step.
    localparam logic [SEQ_LEN_DEF-1:0] EXIT_OFF_DEF  = 5'b11101;
    localparam logic [SEQ_LEN_DEF-1:0] EXIT_LAT_DEF  = 5'b00000;

    // Brightness code layout.
    localparam int CODE_W_DEF   = 8;
    localparam int GAIN_W_DEF   = 6;
    localparam int HC_BIT_DEF   = 1;
    localparam int GAIN_LSB_DEF = 2;

    typedef enum logic {
        MODE_NORMAL  = 1'b0,
        MODE_SPECIAL = 1'b1
    } ledctl_mode_e;

endpackage

// File: rtl/ledctl_pair_window.sv
// Module: keeps the last SEQ_LEN-1 (output-off, strobe) samples. Together
// with the current sample they form a window for the pattern matchers.
// A depth counter tells how many past samples are valid since reset or
// since the last restart.
// Assumes: SEQ_LEN >= 3. The current sample sits in the top bit of the
// window, and older samples sit in lower bits.
module ledctl_pair_window #(
    parameter int SEQ_LEN = 5,
    parameter int CNT_W   = $clog2(SEQ_LEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic               cur_off,
    input  logic               cur_lat,
    output logic [SEQ_LEN-1:0] win_off,
    output logic [SEQ_LEN-1:0] win_lat,
    output logic [CNT_W-1:0]   depth
);

    localparam int HW = SEQ_LEN - 1;

    logic [HW-1:0] hist_off;
    logic [HW-1:0] hist_lat;

    // Shift the newest sample in at the top and drop the oldest.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_off <= '0;
            hist_lat <= '0;
        end else begin
            hist_off <= {cur_off, hist_off[HW-1:1]};
            hist_lat <= {cur_lat, hist_lat[HW-1:1]};
        end
    end

    // Count valid past samples; a restart discards every one of them.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            depth <= '0;
        end else if (depth != CNT_W'(HW)) begin
            depth <= depth + 1'b1;
        end
    end

    assign win_off = {cur_off, hist_off};
    assign win_lat = {cur_lat, hist_lat};

endmodule

// File: rtl/ledctl_pattern_match.sv
// Module: compares the sample window against one fixed pattern.
// prefix_hit is set when the newest k samples equal the first k steps of
// the pattern, for some k. full_hit is set for a match of all steps.
// Assumes: the window layout of ledctl_pair_window and the pattern
// layout of ledctl_mode_pkg.
module ledctl_pattern_match #(
    parameter int                 SEQ_LEN = 5,
    parameter int                 CNT_W   = $clog2(SEQ_LEN),
    parameter logic [SEQ_LEN-1:0] PAT_OFF = '0,
    parameter logic [SEQ_LEN-1:0] PAT_LAT = '0
) (
    input  logic [SEQ_LEN-1:0] win_off,
    input  logic [SEQ_LEN-1:0] win_lat,
    input  logic [CNT_W-1:0]   depth,
    output logic               full_hit,
    output logic               prefix_hit
);

    logic [SEQ_LEN-1:0] pre;

    // One comparator per prefix length k = g+1.
    for (genvar g = 0; g < SEQ_LEN; g++) begin : g_pre
        localparam int K = g + 1;
        logic same;
        assign same = (win_off[SEQ_LEN-1 -: K] == PAT_OFF[K-1:0]) &&
                      (win_lat[SEQ_LEN-1 -: K] == PAT_LAT[K-1:0]);
        if (K == 1) begin : g_first
            assign pre[g] = same;
        end else begin : g_more
            assign pre[g] = same && (depth >= CNT_W'(K - 1));
        end
    end

    assign full_hit   = pre[SEQ_LEN-1];
    assign prefix_hit = |pre;

endmodule

// File: rtl/ledctl_bright_reg.sv
// Module: the brightness register. It holds the range bit and the gain
// field, presets both to all ones at reset, and reloads them from the
// shift register on a load cycle.
// Assumes: HC_BIT lies below GAIN_LSB. Code bits below HC_BIT are reserved.
module ledctl_bright_reg #(
    parameter int CODE_W   = 8,
    parameter int GAIN_W   = 6,
    parameter int HC_BIT   = 1,
    parameter int GAIN_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CODE_W-1:0] din,
    output logic              hc_range,
    output logic [GAIN_W-1:0] gain
);

    localparam int GAIN_MSB = GAIN_LSB + GAIN_W - 1;

    // Reserved low bits are accepted but have nowhere to go.
    logic unused_reserved;
    assign unused_reserved = ^din[HC_BIT:0] ^ din[HC_BIT];

    // Hold the code; preset all ones; reload only on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc_range <= 1'b1;
            gain     <= '1;
        end else if (load) begin
            hc_range <= din[HC_BIT];
            gain     <= din[GAIN_MSB:GAIN_LSB];
        end
    end

endmodule

// File: rtl/ledctl_mode_seq.sv
// Module: the special-mode sequencer. It watches the (output-off, strobe)
// pins across five serial clock edges and switches between normal mode
// and special mode. In special mode it redirects the strobe into the
// brightness register. It also gates the output latch and requests a
// data clear on the return to normal mode.
// Assumes: clk is the serial clock and all pins are already synchronous
// to it.
module ledctl_mode_seq
    import ledctl_mode_pkg::*;
#(
    parameter int                 SEQ_LEN   = SEQ_LEN_DEF,
    parameter logic [SEQ_LEN-1:0] ENTRY_OFF = ENTRY_OFF_DEF,
    parameter logic [SEQ_LEN-1:0] ENTRY_LAT = ENTRY_LAT_DEF,
    parameter logic [SEQ_LEN-1:0] EXIT_OFF  = EXIT_OFF_DEF,
    parameter logic [SEQ_LEN-1:0] EXIT_LAT  = EXIT_LAT_DEF,
    parameter int                 CODE_W    = CODE_W_DEF,
    parameter int                 GAIN_W    = GAIN_W_DEF,
    parameter int                 HC_BIT    = HC_BIT_DEF,
    parameter int                 GAIN_LSB  = GAIN_LSB_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              outs_off,
    input  logic              strobe,
    input  logic [CODE_W-1:0] shreg,
    output logic              special_mode,
    output logic              latch_inhibit,
    output logic              data_clear,
    output logic              hc_range,
    output logic [GAIN_W-1:0] gain
);

    localparam int CNT_W = $clog2(SEQ_LEN);

    ledctl_mode_e       mode_q;
    logic [SEQ_LEN-1:0] win_off;
    logic [SEQ_LEN-1:0] win_lat;
    logic [CNT_W-1:0]   depth;
    logic               entry_hit;
    logic               entry_pre;
    logic               exit_hit;
    logic               exit_pre;
    logic               go_special;
    logic               go_normal;

    // Sample window shared by both matchers.
    ledctl_pair_window #(
        .SEQ_LEN (SEQ_LEN),
        .CNT_W   (CNT_W)
    ) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (go_special || go_normal),
        .cur_off (outs_off),
        .cur_lat (strobe),
        .win_off (win_off),
        .win_lat (win_lat),
        .depth   (depth)
    );

    ledctl_pattern_match #(
        .SEQ_LEN (SEQ_LEN),
        .CNT_W   (CNT_W),
        .PAT_OFF (ENTRY_OFF),
        .PAT_LAT (ENTRY_LAT)
    ) u_entry (
        .win_off    (win_off),
        .win_lat    (win_lat),
        .depth      (depth),
        .full_hit   (entry_hit),
        .prefix_hit (entry_pre)
    );

    ledctl_pattern_match #(
        .SEQ_LEN (SEQ_LEN),
        .CNT_W   (CNT_W),
        .PAT_OFF (EXIT_OFF),
        .PAT_LAT (EXIT_LAT)
    ) u_exit (
        .win_off    (win_off),
        .win_lat    (win_lat),
        .depth      (depth),
        .full_hit   (exit_hit),
        .prefix_hit (exit_pre)
    );

    // Exit prefixes carry no strobe, so nothing depends on them.
    logic unused_exit_pre;
    assign unused_exit_pre = exit_pre;

    // Each pattern counts only in the mode that it leaves.
    always_comb begin
        go_special = (mode_q == MODE_NORMAL)  && entry_hit;
        go_normal  = (mode_q == MODE_SPECIAL) && exit_hit;
    end

    // Mode register: power-on normal, flipped only by a full pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NORMAL;
        end else if (go_special) begin
            mode_q <= MODE_SPECIAL;
        end else if (go_normal) begin
            mode_q <= MODE_NORMAL;
        end
    end

    ledctl_bright_reg #(
        .CODE_W   (CODE_W),
        .GAIN_W   (GAIN_W),
        .HC_BIT   (HC_BIT),
        .GAIN_LSB (GAIN_LSB)
    ) u_bright (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     ((mode_q == MODE_SPECIAL) && strobe),
        .din      (shreg),
        .hc_range (hc_range),
        .gain     (gain)
    );

    // Output latch gating and the clear request toward the data path.
    always_comb begin
        special_mode  = (mode_q == MODE_SPECIAL);
        latch_inhibit = special_mode || (strobe && entry_pre);
        data_clear    = go_normal;
    end

endmodule

// File: rtl/ledctl_mode_seq_chk.sv
// Module: property checker for ledctl_mode_seq. It is bound to every
// instance and sees only the top-level ports.
// Assumes: the same parameter values as the instance it watches.
module ledctl_mode_seq_chk #(
    parameter int                 SEQ_LEN   = 5,
    parameter logic [SEQ_LEN-1:0] ENTRY_OFF = 5'b11101,
    parameter logic [SEQ_LEN-1:0] ENTRY_LAT = 5'b01000,
    parameter int                 CODE_W    = 8,
    parameter int                 GAIN_W    = 6,
    parameter int                 HC_BIT    = 1,
    parameter int                 GAIN_LSB  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              outs_off,
    input logic              strobe,
    input logic [CODE_W-1:0] shreg,
    input logic              special_mode,
    input logic              latch_inhibit,
    input logic              data_clear,
    input logic              hc_range,
    input logic [GAIN_W-1:0] gain
);

    localparam int GAIN_MSB = GAIN_LSB + GAIN_W - 1;

    // R3: one edge after reset, the mode is normal and the code is all ones.
    assert_reset_state_R3: assert property (@(posedge clk)
        !rst_n |=> (!special_mode && hc_range && (gain == '1)));

    // R5: a special-mode strobe sample lands the shift register fields.
    assert_load_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (special_mode && strobe) |=>
            (hc_range == $past(shreg[HC_BIT])) &&
            (gain == $past(shreg[GAIN_MSB:GAIN_LSB])));

    // R5: the output latch stays blocked throughout special mode.
    assert_inhibit_special_R5: assert property (@(posedge clk) disable iff (!rst_n)
        special_mode |-> latch_inhibit);

    // R7: without a special-mode strobe the brightness code holds.
    assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(special_mode && strobe) |=> ($stable(hc_range) && $stable(gain)));

    // R8: a clear request only comes while leaving special mode.
    assert_clear_in_special_R8: assert property (@(posedge clk) disable iff (!rst_n)
        data_clear |-> special_mode);

    assert_clear_exits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        data_clear |=> !special_mode);

    // R2: every fall of the mode outside reset was announced by a clear.
    assert_exit_announced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(special_mode) && $past(rst_n)) |-> $past(data_clear));

    // R1: entry happens on a sample equal to the final entry step.
    assert_entry_last_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(special_mode) |->
            (($past(outs_off) == ENTRY_OFF[SEQ_LEN-1]) &&
             ($past(strobe) == ENTRY_LAT[SEQ_LEN-1])));

endmodule

bind ledctl_mode_seq ledctl_mode_seq_chk #(
    .SEQ_LEN   (SEQ_LEN),
    .ENTRY_OFF (ENTRY_OFF),
    .ENTRY_LAT (ENTRY_LAT),
    .CODE_W    (CODE_W),
    .GAIN_W    (GAIN_W),
    .HC_BIT    (HC_BIT),
    .GAIN_LSB  (GAIN_LSB)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .outs_off      (outs_off),
    .strobe        (strobe),
    .shreg         (shreg),
    .special_mode  (special_mode),
    .latch_inhibit (latch_inhibit),
    .data_clear    (data_clear),
    .hc_range      (hc_range),
    .gain          (gain)
);

// File: tb/ledctl_mode_seq_tb.sv
`timescale 1ns/1ps
module ledctl_mode_seq_tb;

    localparam int NV = 45;

    // Row layout: req[24:21] off[20] lat[19] data[18:11] inh[10] clr[9]
    // mode[8] code[7:0]. The code field is the expected brightness code.
    function automatic logic [24:0] row(input int req, input bit off, input bit lat,
                                        input logic [7:0] d, input bit inh,
                                        input bit clr, input bit md,
                                        input logic [7:0] code);
        return {4'(req), off, lat, d, inh, clr, md, code};
    endfunction

    localparam logic [24:0] VEC [NV] = '{
        row(4, 0, 1, 8'h00, 0, 0, 0, 8'hFF),   // 0  R4 plain strobe
        row(1, 1, 0, 8'h00, 0, 0, 0, 8'hFF),   // 1  R1 entry step 0
        row(1, 0, 0, 8'h00, 0, 0, 0, 8'hFF),   // 2
        row(1, 1, 0, 8'h00, 0, 0, 0, 8'hFF),   // 3
        row(10, 1, 1, 8'h3C, 1, 0, 0, 8'hFF),  // 4  R10 strobe inside entry
        row(1, 1, 0, 8'h00, 0, 0, 1, 8'hFF),   // 5  R1 enters special
        row(5, 0, 1, 8'h5A, 1, 0, 1, 8'h5A),   // 6  R5 load 0x5A (R6 hc=1 gain=22)
        row(5, 0, 0, 8'h00, 1, 0, 1, 8'h5A),   // 7
        row(2, 1, 0, 8'h00, 1, 0, 1, 8'h5A),   // 8  R2 near miss exit
        row(2, 0, 0, 8'h00, 1, 0, 1, 8'h5A),   // 9
        row(2, 1, 0, 8'h00, 1, 0, 1, 8'h5A),   // 10
        row(2, 1, 0, 8'h00, 1, 0, 1, 8'h5A),   // 11
        row(2, 0, 0, 8'h00, 1, 0, 1, 8'h5A),   // 12 wrong last step
        row(2, 1, 0, 8'h00, 1, 0, 1, 8'h5A),   // 13 R2 real exit
        row(2, 0, 0, 8'h00, 1, 0, 1, 8'h5A),   // 14
        row(2, 1, 0, 8'h00, 1, 0, 1, 8'h5A),   // 15
        row(2, 1, 0, 8'h00, 1, 0, 1, 8'h5A),   // 16
        row(8, 1, 0, 8'h00, 1, 1, 0, 8'h5A),   // 17 R8 clear on exit
        row(7, 0, 1, 8'h00, 0, 0, 0, 8'h5A),   // 18 R7 code kept, R4 no inhibit
        row(1, 1, 0, 8'h00, 0, 0, 0, 8'h5A),   // 19 R1 near miss entry
        row(1, 0, 0, 8'h00, 0, 0, 0, 8'h5A),   // 20
        row(1, 1, 0, 8'h00, 0, 0, 0, 8'h5A),   // 21
        row(10, 1, 1, 8'h77, 1, 0, 0, 8'h5A),  // 22 R10
        row(1, 0, 0, 8'h00, 0, 0, 0, 8'h5A),   // 23 stays normal
        row(1, 1, 0, 8'h00, 0, 0, 0, 8'h5A),   // 24 R1 restart case
        row(1, 1, 0, 8'h00, 0, 0, 0, 8'h5A),   // 25
        row(1, 0, 0, 8'h00, 0, 0, 0, 8'h5A),   // 26
        row(1, 1, 0, 8'h00, 0, 0, 0, 8'h5A),   // 27
        row(10, 1, 1, 8'h00, 1, 0, 0, 8'h5A),  // 28
        row(1, 1, 0, 8'h00, 0, 0, 1, 8'h5A),   // 29 enters special
        row(9, 0, 0, 8'h00, 1, 0, 1, 8'h5A),   // 30 R9 stale window
        row(9, 1, 0, 8'h00, 1, 0, 1, 8'h5A),   // 31
        row(9, 1, 0, 8'h00, 1, 0, 1, 8'h5A),   // 32
        row(9, 1, 0, 8'h00, 1, 0, 1, 8'h5A),   // 33 no exit yet
        row(6, 0, 1, 8'h81, 1, 0, 1, 8'h81),   // 34 R6 hc=0 gain=32
        row(2, 1, 0, 8'h00, 1, 0, 1, 8'h81),   // 35 exit again
        row(2, 0, 0, 8'h00, 1, 0, 1, 8'h81),   // 36
        row(2, 1, 0, 8'h00, 1, 0, 1, 8'h81),   // 37
        row(2, 1, 0, 8'h00, 1, 0, 1, 8'h81),   // 38
        row(8, 1, 0, 8'h00, 1, 1, 0, 8'h81),   // 39 R8
        row(8, 1, 0, 8'h00, 0, 0, 0, 8'h81),   // 40 R8 exit while normal
        row(8, 0, 0, 8'h00, 0, 0, 0, 8'h81),   // 41
        row(8, 1, 0, 8'h00, 0, 0, 0, 8'h81),   // 42
        row(8, 1, 0, 8'h00, 0, 0, 0, 8'h81),   // 43
        row(8, 1, 0, 8'h00, 0, 0, 0, 8'h81)    // 44 no clear
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       outs_off = 1'b0;
    logic       strobe = 1'b0;
    logic [7:0] shreg = 8'h00;
    logic       special_mode;
    logic       latch_inhibit;
    logic       data_clear;
    logic       hc_range;
    logic [5:0] gain;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ledctl_mode_seq u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .outs_off      (outs_off),
        .strobe        (strobe),
        .shreg         (shreg),
        .special_mode  (special_mode),
        .latch_inhibit (latch_inhibit),
        .data_clear    (data_clear),
        .hc_range      (hc_range),
        .gain          (gain)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one sample at the falling edge, check combinational outputs,
    // then check registered outputs just after the rising edge.
    task automatic step(input bit off, input bit lat, input logic [7:0] d,
                        input bit inh, input bit clr, input bit md,
                        input logic [7:0] code, input string tag);
        @(negedge clk);
        outs_off = off;
        strobe   = lat;
        shreg    = d;
        #0.5;
        check({tag, " latch_inhibit"}, {7'd0, latch_inhibit}, {7'd0, inh});
        check({tag, " data_clear"}, {7'd0, data_clear}, {7'd0, clr});
        @(posedge clk);
        #0.5;
        check({tag, " special_mode"}, {7'd0, special_mode}, {7'd0, md});
        check({tag, " code"}, {gain, hc_range, 1'b0}, {code[7:1], 1'b0});
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            total++;
            $display("FAIL R3 watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R3: reset state
        repeat (3) @(posedge clk);
        #0.5;
        check("R3 reset special_mode", {7'd0, special_mode}, 8'd0);
        check("R3 reset code", {gain, hc_range, 1'b0}, 8'hFE);
        check("R3 reset latch_inhibit", {7'd0, latch_inhibit}, 8'd0);
        check("R3 reset data_clear", {7'd0, data_clear}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            step(v[20], v[19], v[18:11], v[10], v[9], v[8], v[7:0],
                 $sformatf("R%0d row %0d", v[24:21], i));
        end

        // R6: reserved bit 0 is ignored; 0xFE gives hc=1 gain=63
        step(1, 0, 8'h00, 0, 0, 0, 8'h81, "R1 entry a");
        step(0, 0, 8'h00, 0, 0, 0, 8'h81, "R1 entry b");
        step(1, 0, 8'h00, 0, 0, 0, 8'h81, "R1 entry c");
        step(1, 1, 8'h00, 1, 0, 0, 8'h81, "R10 entry d");
        step(1, 0, 8'h00, 0, 0, 1, 8'h81, "R1 entry e");
        step(0, 1, 8'hFE, 1, 0, 1, 8'hFE, "R6 reserved bit");
        step(0, 1, 8'h24, 1, 0, 1, 8'h24, "R6 hc=0 gain=9");

        // R3: reset from special mode returns to the power-on state
        @(negedge clk);
        outs_off = 1'b0;
        strobe   = 1'b0;
        rst_n    = 1'b0;
        @(posedge clk);
        #0.5;
        check("R3 mid reset special_mode", {7'd0, special_mode}, 8'd0);
        check("R3 mid reset code", {gain, hc_range, 1'b0}, 8'hFE);
        check("R3 mid reset data_clear", {7'd0, data_clear}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 1, 8'h00, 0, 0, 0, 8'hFF, "R4 strobe after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule